// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that lets an external controller read and write a small configuration register file over a chip-select, serial-clock, data-in and data-out link. Every transaction opens with a 16-bit command word. The command word carries a direction flag, a two-bit length code and a 13-bit starting register address. Data bytes follow the command word, and the register address steps by one after each byte.

The serial pins are sampled by the block's own system clock. Two flops bring each pin into that clock, and edge detectors follow the flops. For this reason the serial clock must run well below the system clock; the bench uses twelve system cycles per serial bit. The serial link has no flow control. The controller owns the serial clock, and the slave must keep pace with every edge, so there is no back-pressure path.

The register file contains:
- a port-control register, which holds the bit-order selection and a self-clearing soft-reset command;
- a burst-stop address;
- two read-only identification bytes;
- a converter-select register;
- a bank of trim registers. The trim registers can be reached only while the converter-select register enables them. The trim values leave the block as a flat vector.

Top module: `spi_cfg_port`

## Requirements
- R1: A transaction starts on the first rising serial-clock edge after chip select (active low) falls. The first 16 bits form a command word: bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code, and bits 12:0 are the start address. In MSB-first order the word is sent from bit 15 down to bit 0. In LSB-first order it is sent from bit 0 up to bit 15.
- R2: Length codes 00, 01 and 10 move exactly 1, 2 and 3 data bytes. Bits that follow on the same chip-select low period are decoded as a new command word.
- R3: Length code 11 moves bytes for as long as chip select stays low. If chip select rises after at least one data byte has completed, the transfer ends, and the next bits are taken as a new command word.
- R4: Chip select may go high at a byte boundary without losing state in these cases: for codes 00 to 10, at any byte boundary; for code 11, between the two command bytes or before the first data byte. The transfer then resumes when chip select falls again.
- R5: If chip select rises in the middle of a byte, the partial byte is discarded and nothing is written. The block then waits for a new command word.
- R6: Bit 6 of register 0x000 set to 1 selects LSB-first order for command and data bits, and the address then decrements after each data byte. When the bit is 0 (the reset value), the order is MSB-first and the address increments.
- R7: Read data is updated after falling serial-clock edges and after a chip-select fall, so each bit is valid at the next rising edge. The first data bit is valid at the first rising edge after the command word. `spi_sdo_oe` is high only during the data phase of a read while chip select is low.
- R8: Register 0x000 reads as {b7, b6, 0, 1, 1, 0, b6, b7}, where b7 and b6 are the written bits 7 and 6; its reset read value is 0x18. Writing it with bit 5 set returns every writable register to its reset value: trims 0x80, and 0x00 for the burst stop, the converter select and the port bits.
- R9: Under length code 11, the transfer ends after the byte at the address equal to register 0x002 (zero-extended) has been moved. The next bits are decoded as a new command word, with no chip-select rise needed.
- R10: Only bit 0 of register 0x010 is stored. While that bit is 0, reads of the trim registers 0x020 to 0x023 return 0xAD and writes to them are ignored.
- R11: Register 0x008 reads as 0x5A and register 0x009 reads as 0x03. Writes to either are ignored.
- R12: Reads of unmapped addresses return 0x00, and writes to them change nothing.
- R13: A written byte takes effect, and appears on `trim_values` (byte g at bits 8g+7:8g), only after all eight of its bits have arrived. After reset every trim byte is 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csb | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the controller; low when idle |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial read data out of the block |
| spi_sdo_oe | output | 1 | High while `spi_sdo` carries read data |
| trim_values | output | NUM_TRIM*8 | Current contents of the trim registers |

## Verification
The bench starts by sweeping single-byte reads across the lower 48 addresses. This sweep separates mapped registers, unmapped addresses, the identification bytes and the gated trim error code. Next, writes and reads are run under every length code, with chained command words inside one chip-select period. These runs show whether the byte count ends a transfer at the right byte and whether the next bits are decoded as a command. Chip select is then raised between command bytes, between data bytes, after a streamed byte and in the middle of a byte. These cases separate a permitted pause from an abort and from a discarded partial byte. Finally, the same streaming and burst-stop sequences run again in LSB-first order, followed by a soft reset. These runs show the reversed bit assembly, the decrementing address and the return to default values.

// File: rtl/spicfg_pkg.sv
package spicfg_pkg;

  localparam int ADDR_W = 13;

  localparam logic [ADDR_W-1:0] A_PORTCFG   = 13'h000;
  localparam logic [ADDR_W-1:0] A_BURSTEND  = 13'h002;
  localparam logic [ADDR_W-1:0] A_CHIPID    = 13'h008;
  localparam logic [ADDR_W-1:0] A_CHIPREV   = 13'h009;
  localparam logic [ADDR_W-1:0] A_DEVSEL    = 13'h010;
  localparam logic [ADDR_W-1:0] A_TRIM_BASE = 13'h020;

  localparam logic [7:0] SEL_ERR_CODE = 8'hAD;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic down);
    return down ? a - 13'd1 : a + 13'd1;
  endfunction

endpackage

// File: rtl/spicfg_pin_sync.sv
module spicfg_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csb_pin,
  input  logic sclk_pin,
  input  logic sdi_pin,
  output logic csb_s,
  output logic sdi_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic csb_rise,
  output logic csb_fall
);

  // bit 2 = chip select, bit 1 = serial clock, bit 0 = data
  localparam logic [2:0] IDLE_VAL = 3'b100;

  logic [SYNC_STAGES-1:0][2:0] pipe;
  logic [2:0] last;
  logic       sclk_d, csb_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {SYNC_STAGES{IDLE_VAL}};
    end else begin
      pipe[0] <= {csb_pin, sclk_pin, sdi_pin};
      for (int s = 1; s < SYNC_STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign last = pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csb_d  <= 1'b1;
    end else begin
      sclk_d <= last[1];
      csb_d  <= last[2];
    end
  end

  assign csb_s     = last[2];
  assign sdi_s     = last[0];
  assign sclk_rise =  last[1] & ~sclk_d & ~last[2];
  assign sclk_fall = ~last[1] &  sclk_d & ~last[2];
  assign csb_rise  =  last[2] & ~csb_d;
  assign csb_fall  = ~last[2] &  csb_d;

endmodule

// File: rtl/spicfg_regs.sv
module spicfg_regs
  import spicfg_pkg::*;
#(
  parameter int         NUM_TRIM   = 4,
  parameter logic [7:0] TRIM_RESET = 8'h80,
  parameter logic [7:0] CHIP_ID    = 8'h5A,
  parameter logic [7:0] CHIP_REV   = 8'h03
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  output logic                  lsb_first,
  output logic [7:0]            burst_end,
  output logic [NUM_TRIM*8-1:0] trim_values
);

  logic       out_act, lsb_q, sel_q;
  logic [7:0] bend_q;
  logic       soft_rst;

  assign soft_rst = wr_en && (wr_addr == A_PORTCFG) && wr_data[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_act <= 1'b0;
      lsb_q   <= 1'b0;
      sel_q   <= 1'b0;
      bend_q  <= 8'h00;
    end else if (soft_rst) begin
      out_act <= 1'b0;
      lsb_q   <= 1'b0;
      sel_q   <= 1'b0;
      bend_q  <= 8'h00;
    end else if (wr_en) begin
      case (wr_addr)
        A_PORTCFG:  {out_act, lsb_q} <= wr_data[7:6];
        A_BURSTEND: bend_q <= wr_data;
        A_DEVSEL:   sel_q  <= wr_data[0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_TRIM; g++) begin : g_trim
    localparam logic [ADDR_W-1:0] MY_ADDR = A_TRIM_BASE + 13'(g);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    q <= TRIM_RESET;
      else if (soft_rst)                             q <= TRIM_RESET;
      else if (wr_en && sel_q && wr_addr == MY_ADDR) q <= wr_data;
    end
    assign trim_values[g*8 +: 8] = q;
  end

  always_comb begin
    rd_data = 8'h00;
    case (rd_addr)
      A_PORTCFG:  rd_data = {out_act, lsb_q, 1'b0, 1'b1, 1'b1, 1'b0, lsb_q, out_act};
      A_BURSTEND: rd_data = bend_q;
      A_CHIPID:   rd_data = CHIP_ID;
      A_CHIPREV:  rd_data = CHIP_REV;
      A_DEVSEL:   rd_data = {7'd0, sel_q};
      default: begin
        for (int g = 0; g < NUM_TRIM; g++) begin
          if (rd_addr == A_TRIM_BASE + 13'(g))
            rd_data = sel_q ? trim_values[g*8 +: 8] : SEL_ERR_CODE;
        end
      end
    endcase
  end

  assign lsb_first = lsb_q;
  assign burst_end = bend_q;

  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_PORTCFG && wr_data[5]) |=>
      (!lsb_q && !out_act && !sel_q && bend_q == 8'h00 &&
       trim_values == {NUM_TRIM{TRIM_RESET}}));

  assert_trim_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_q && wr_addr != A_PORTCFG) |=> $stable(trim_values));

endmodule

// File: rtl/spicfg_frame.sv
module spicfg_frame
  import spicfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb_s,
  input  logic              sdi_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              csb_rise,
  input  logic              csb_fall,
  input  logic              lsb_first,
  input  logic [7:0]        burst_end,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              sdo,
  output logic              sdo_oe
);

  phase_e            phase;
  logic [3:0]        bitcnt;
  logic [15:0]       shreg, nxt_sh;
  logic              is_read;
  logic [1:0]        code;
  logic [ADDR_W-1:0] addr, step;
  logic [1:0]        nbytes;
  logic              streamed;
  logic [7:0]        tx_byte, rx_byte;
  logic              sdo_q;
  logic              xfer_end, byte_done;
  logic [2:0]        bsel;

  assign nxt_sh    = lsb_first ? {sdi_s, shreg[15:1]} : {shreg[14:0], sdi_s};
  assign rx_byte   = lsb_first ? nxt_sh[15:8] : nxt_sh[7:0];
  assign step      = step_addr(addr, lsb_first);
  assign xfer_end  = (code == 2'b11) ? (addr == {5'd0, burst_end}) : (nbytes == code);
  assign rd_addr   = (phase == PH_CMD) ? nxt_sh[12:0] : step;
  assign bsel      = lsb_first ? bitcnt[2:0] : ~bitcnt[2:0];
  assign byte_done = sclk_rise && phase == PH_DATA && bitcnt == 4'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      bitcnt   <= 4'd0;
      shreg    <= 16'd0;
      is_read  <= 1'b0;
      code     <= 2'b00;
      addr     <= '0;
      nbytes   <= 2'd0;
      streamed <= 1'b0;
      tx_byte  <= 8'd0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= 8'd0;
    end else begin
      wr_en <= 1'b0;
      if (csb_rise) begin
        if (bitcnt[2:0] != 3'd0 || (phase == PH_DATA && code == 2'b11 && streamed)) begin
          phase  <= PH_CMD;
          bitcnt <= 4'd0;
        end
      end else if (sclk_rise) begin
        shreg <= nxt_sh;
        if (phase == PH_CMD) begin
          if (bitcnt == 4'd15) begin
            phase    <= PH_DATA;
            bitcnt   <= 4'd0;
            is_read  <= nxt_sh[15];
            code     <= nxt_sh[14:13];
            addr     <= nxt_sh[12:0];
            nbytes   <= 2'd0;
            streamed <= 1'b0;
            tx_byte  <= rd_data;
          end else begin
            bitcnt <= bitcnt + 4'd1;
          end
        end else if (bitcnt == 4'd7) begin
          bitcnt   <= 4'd0;
          streamed <= 1'b1;
          if (!is_read) begin
            wr_en   <= 1'b1;
            wr_addr <= addr;
            wr_data <= rx_byte;
          end
          if (xfer_end) begin
            phase <= PH_CMD;
          end else begin
            addr    <= step;
            nbytes  <= nbytes + 2'd1;
            tx_byte <= rd_data;
          end
        end else begin
          bitcnt <= bitcnt + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     sdo_q <= 1'b0;
    else if (sclk_fall || csb_fall) sdo_q <= tx_byte[bsel];
  end

  assign sdo    = sdo_q;
  assign sdo_oe = !csb_s && phase == PH_DATA && is_read;

  assert_commit_after_edge_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(sclk_rise));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !xfer_end) |=> addr == step_addr($past(addr), $past(lsb_first)));

  assert_abort_midbyte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (csb_rise && bitcnt[2:0] != 3'd0) |=> (phase == PH_CMD && bitcnt == 4'd0 && !wr_en));

  assert_sdo_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(sclk_fall || csb_fall));

endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spicfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_TRIM    = 4,
  parameter logic [7:0] TRIM_RESET  = 8'h80,
  parameter logic [7:0] CHIP_ID     = 8'h5A,
  parameter logic [7:0] CHIP_REV    = 8'h03
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_csb,
  input  logic                  spi_sclk,
  input  logic                  spi_sdi,
  output logic                  spi_sdo,
  output logic                  spi_sdo_oe,
  output logic [NUM_TRIM*8-1:0] trim_values
);

  logic              csb_s, sdi_s, sclk_rise, sclk_fall, csb_rise, csb_fall;
  logic              lsb_first;
  logic [7:0]        burst_end, rd_data, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              wr_en;

  spicfg_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .csb_pin   (spi_csb),
    .sclk_pin  (spi_sclk),
    .sdi_pin   (spi_sdi),
    .csb_s     (csb_s),
    .sdi_s     (sdi_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .csb_rise  (csb_rise),
    .csb_fall  (csb_fall)
  );

  spicfg_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .csb_s     (csb_s),
    .sdi_s     (sdi_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .csb_rise  (csb_rise),
    .csb_fall  (csb_fall),
    .lsb_first (lsb_first),
    .burst_end (burst_end),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sdo       (spi_sdo),
    .sdo_oe    (spi_sdo_oe)
  );

  spicfg_regs #(
    .NUM_TRIM   (NUM_TRIM),
    .TRIM_RESET (TRIM_RESET),
    .CHIP_ID    (CHIP_ID),
    .CHIP_REV   (CHIP_REV)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .lsb_first   (lsb_first),
    .burst_end   (burst_end),
    .trim_values (trim_values)
  );

endmodule

// File: tb/spi_cfg_port_bench.sv
`timescale 1ns/1ps
module spi_cfg_port_bench;

  localparam int H = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        csb = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic        sdo, oe;
  logic [31:0] trims;

  spi_cfg_port u_spi_cfg_port (
    .clk(clk), .rst_n(rst_n), .spi_csb(csb), .spi_sclk(sclk), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_oe(oe), .trim_values(trims)
  );

  int   total = 0, bad = 0;
  bit   done = 1'b0;
  bit   lsb_m = 1'b0;
  logic last_oe;
  logic [7:0] rv;

  logic [7:0] m_trim [4];
  logic       m_b7, m_lsb, m_sel;
  logic [7:0] m_bend;

  function automatic void model_reset();
    for (int g = 0; g < 4; g++) m_trim[g] = 8'h80;
    m_b7 = 1'b0; m_lsb = 1'b0; m_sel = 1'b0; m_bend = 8'h00;
  endfunction

  function automatic void mwrite(input logic [12:0] a, input logic [7:0] v);
    if (a == 13'h000) begin
      if (v[5]) model_reset();
      else begin m_b7 = v[7]; m_lsb = v[6]; end
    end else if (a == 13'h002) m_bend = v;
    else if (a == 13'h010) m_sel = v[0];
    else if (a >= 13'h020 && a <= 13'h023 && m_sel) m_trim[a - 13'h020] = v;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [12:0] a);
    if (a == 13'h000) return {m_b7, m_lsb, 1'b0, 1'b1, 1'b1, 1'b0, m_lsb, m_b7};
    if (a == 13'h002) return m_bend;
    if (a == 13'h008) return 8'h5A;
    if (a == 13'h009) return 8'h03;
    if (a == 13'h010) return {7'd0, m_sel};
    if (a >= 13'h020 && a <= 13'h023) return m_sel ? m_trim[a - 13'h020] : 8'hAD;
    return 8'h00;
  endfunction

  function automatic logic [31:0] exp_trims();
    return {m_trim[3], m_trim[2], m_trim[1], m_trim[0]};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < n; i++) begin
      int b;
      b = lsb_m ? i : 7 - i;
      sdi = tx[b];
      wait_clk(H);
      rx[b] = sdo;
      last_oe = oe;
      sclk = 1'b1;
      wait_clk(H);
      sclk = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    pbits(tx, 8, rx);
  endtask

  task automatic sel();
    wait_clk(H); csb = 1'b0; wait_clk(2*H);
  endtask

  task automatic desel();
    wait_clk(H); csb = 1'b1; wait_clk(3*H);
  endtask

  task automatic cmd(input bit rd, input logic [1:0] code, input logic [12:0] a);
    logic [15:0] w;
    logic [7:0]  d;
    w = {rd, code, a};
    if (lsb_m) begin xbyte(w[7:0], d);  xbyte(w[15:8], d); end
    else       begin xbyte(w[15:8], d); xbyte(w[7:0], d);  end
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] v);
    logic [7:0] d;
    sel(); cmd(1'b0, 2'b00, a); xbyte(v, d); desel();
    mwrite(a, v);
  endtask

  task automatic rd1(input logic [12:0] a, output logic [7:0] v);
    sel(); cmd(1'b1, 2'b00, a); xbyte(8'h00, v); desel();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    model_reset();
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(5);

    // reset state: R13 trims at 0x80, R7 output enable low
    check("R13 reset trims", trims, exp_trims());
    check("R7 reset oe", {31'd0, oe}, 32'd0);

    // R1 R10 R11 R12 sweep of single reads
    for (int a = 0; a < 48; a++) begin
      rd1(13'(a), rv);
      check($sformatf("R1 R10 R11 R12 sweep addr %0h", a), {24'd0, rv}, {24'd0, exp_rd(13'(a))});
    end

    // R3 R13: stream write under code 11, ended by chip select
    wr1(13'h010, 8'h01);
    sel(); cmd(1'b0, 2'b11, 13'h020);
    xbyte(8'h11, d); mwrite(13'h020, 8'h11);
    xbyte(8'h22, d); mwrite(13'h021, 8'h22);
    xbyte(8'h33, d); mwrite(13'h022, 8'h33);
    xbyte(8'h44, d); mwrite(13'h023, 8'h44);
    desel();
    check("R3 R13 stream write", trims, exp_trims());

    // R3 R7: stream read across mapped and unmapped addresses
    sel(); cmd(1'b1, 2'b11, 13'h01E);
    for (int k = 0; k < 8; k++) begin
      xbyte(8'h00, rv);
      check($sformatf("R3 stream read %0d", k), {24'd0, rv}, {24'd0, exp_rd(13'(30 + k))});
      check("R7 oe during read", {31'd0, last_oe}, 32'd1);
    end
    desel();

    // R2: two-byte write, then chained commands in one select period
    sel(); cmd(1'b0, 2'b01, 13'h022);
    xbyte(8'h5C, d); mwrite(13'h022, 8'h5C);
    check("R7 oe low on write", {31'd0, last_oe}, 32'd0);
    xbyte(8'h6D, d); mwrite(13'h023, 8'h6D);
    cmd(1'b1, 2'b10, 13'h020);
    for (int k = 0; k < 3; k++) begin
      xbyte(8'h00, rv);
      check("R2 three-byte read", {24'd0, rv}, {24'd0, exp_rd(13'(32 + k))});
    end
    cmd(1'b1, 2'b00, 13'h023);
    xbyte(8'h00, rv);
    check("R2 chained single read", {24'd0, rv}, {24'd0, exp_rd(13'h023)});
    desel();

    // R4: pauses at every boundary for code 10
    sel(); cmd(1'b0, 2'b10, 13'h021); desel();
    sel(); xbyte(8'hA1, d); desel(); mwrite(13'h021, 8'hA1);
    sel(); xbyte(8'hA2, d); desel(); mwrite(13'h022, 8'hA2);
    sel(); xbyte(8'hA3, d); desel(); mwrite(13'h023, 8'hA3);
    check("R4 paused code 10 write", trims, exp_trims());

    // R4: code 11 pause between command bytes and before first data byte
    sel(); xbyte(8'h60, d); desel();
    sel(); xbyte(8'h20, d); desel();
    sel(); xbyte(8'h3C, d); mwrite(13'h020, 8'h3C);
    xbyte(8'h4D, d); mwrite(13'h021, 8'h4D); desel();
    check("R4 paused code 11 write", trims, exp_trims());

    // R3: chip select rise after a streamed byte ends the transfer
    sel(); cmd(1'b0, 2'b11, 13'h022); xbyte(8'h77, d); mwrite(13'h022, 8'h77); desel();
    sel(); cmd(1'b1, 2'b00, 13'h023); xbyte(8'h00, rv); desel();
    check("R3 abort then new command", {24'd0, rv}, {24'd0, exp_rd(13'h023)});
    check("R3 abort trims", trims, exp_trims());

    // R5: mid-byte abort in data and in command
    sel(); cmd(1'b0, 2'b00, 13'h020); pbits(8'hFF, 4, d); desel();
    check("R5 partial byte discarded", trims, exp_trims());
    rd1(13'h020, rv);
    check("R5 read after data abort", {24'd0, rv}, {24'd0, exp_rd(13'h020)});
    sel(); pbits(8'h80, 5, d); desel();
    rd1(13'h021, rv);
    check("R5 read after command abort", {24'd0, rv}, {24'd0, exp_rd(13'h021)});

    // R9: burst stop address ends a stream without chip select
    wr1(13'h002, 8'h21);
    sel(); cmd(1'b0, 2'b11, 13'h020);
    xbyte(8'h9A, d); mwrite(13'h020, 8'h9A);
    xbyte(8'h9B, d); mwrite(13'h021, 8'h9B);
    cmd(1'b1, 2'b01, 13'h020);
    xbyte(8'h00, rv);
    check("R9 burst stop read 0", {24'd0, rv}, {24'd0, exp_rd(13'h020)});
    xbyte(8'h00, rv);
    check("R9 burst stop read 1", {24'd0, rv}, {24'd0, exp_rd(13'h021)});
    desel();
    check("R9 trims", trims, exp_trims());

    // R6 R8: LSB-first order with decrementing address
    wr1(13'h000, 8'h5A);
    lsb_m = 1'b1;
    rd1(13'h000, rv);
    check("R8 R6 port register", {24'd0, rv}, 32'h5A);
    sel(); cmd(1'b0, 2'b11, 13'h023);
    xbyte(8'hC3, d); mwrite(13'h023, 8'hC3);
    xbyte(8'hC2, d); mwrite(13'h022, 8'hC2);
    xbyte(8'hC1, d); mwrite(13'h021, 8'hC1);
    desel();
    check("R6 decrementing write", trims, exp_trims());
    sel(); cmd(1'b1, 2'b10, 13'h022);
    for (int k = 0; k < 3; k++) begin
      xbyte(8'h00, rv);
      check("R6 decrementing read", {24'd0, rv}, {24'd0, exp_rd(13'(34 - k))});
    end
    desel();

    // R8: soft reset
    sel(); cmd(1'b0, 2'b00, 13'h000); xbyte(8'h20, d); desel();
    mwrite(13'h000, 8'h20);
    lsb_m = 1'b0;
    check("R8 soft reset trims", trims, exp_trims());
    rd1(13'h000, rv); check("R8 port after soft reset", {24'd0, rv}, 32'h18);
    rd1(13'h010, rv); check("R8 select after soft reset", {24'd0, rv}, 32'h00);
    rd1(13'h002, rv); check("R8 burst after soft reset", {24'd0, rv}, 32'h00);

    // R10: gated trims ignore writes and return error code
    wr1(13'h020, 8'h55);
    check("R10 gated write ignored", trims, exp_trims());
    rd1(13'h020, rv); check("R10 gated read", {24'd0, rv}, 32'hAD);
    wr1(13'h010, 8'hFE);
    rd1(13'h010, rv); check("R10 only bit 0 stored", {24'd0, rv}, 32'h00);

    // R11 R12: read-only and unmapped
    wr1(13'h008, 8'h00);
    rd1(13'h008, rv); check("R11 id read-only", {24'd0, rv}, 32'h5A);
    wr1(13'h009, 8'hFF);
    rd1(13'h009, rv); check("R11 rev read-only", {24'd0, rv}, 32'h03);
    wr1(13'h005, 8'h77);
    rd1(13'h005, rv); check("R12 unmapped", {24'd0, rv}, 32'h00);
    check("R12 trims untouched", trims, exp_trims());

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule